// File: doc/BRIEF.md
# Clocked Controller for an Asynchronous 512K x 8 Static RAM

This block connects a clocked host to an external asynchronous static RAM with 524,288 bytes, reached through 19 address lines. The host side is a request/acknowledge port. A request carries an address, a direction flag and, for writes, a byte of data. The controller answers every accepted request with a one-cycle acknowledge. A read returns its byte in the same cycle as the acknowledge.

On the memory side the controller drives active-low chip-select, write-strobe and output-enable pins and a registered address. It also drives a data bus that is split into an outgoing byte, a drive-enable and an incoming byte. Each phase length is a count of clock cycles. The counts are worked out at elaboration from the memory's timing figures, given in picoseconds, and the clock period. Every figure is rounded up to whole cycles, and every phase lasts at least one cycle.

The controller is a five-state machine:

- IDLE: all three strobes are high and the drivers are off. A request is accepted only here. It goes to RD_ACCESS for a read or WR_PULSE for a write.
- RD_ACCESS: chip-select and output-enable are low. When its count ends it goes to RD_TURN.
- RD_TURN: the strobes are high, the drivers stay off, and the memory's outputs are allowed time to float. When its count ends it goes back to IDLE.
- WR_PULSE: chip-select and write-strobe are low, output-enable stays high and the data is driven. When its count ends it goes to WR_HOLD.
- WR_HOLD: write-strobe rises while chip-select stays low and the data is still driven. It always goes back to IDLE after one cycle.

Writes are timed by the write-strobe edge, with output-enable held high so that the shorter write-pulse minimum applies.

Top module: `sram_access_ctrl`

## Requirements
- R1: While reset is asserted, and in IDLE, chip-select, write-strobe and output-enable are high (1), the data drive-enable is 0 and the acknowledge is 0.
- R2: A read holds chip-select low, output-enable low and write-strobe high for exactly RD_CYC consecutive cycles with the address unchanged. The byte present on the incoming bus in the last of those cycles is returned on host_rdata.
- R3: A write holds write-strobe and chip-select low for exactly WP_CYC cycles. Output-enable stays high for the whole pulse, and the outgoing data and the address are driven and stable throughout it.
- R4: In the cycle after write-strobe rises, chip-select is still low and the same data is still driven. Only after that cycle does chip-select rise.
- R5: Each accepted request gives exactly one acknowledge, lasting one cycle. It comes RD_CYC+1 cycles after the accepting edge for a read and WP_CYC+2 cycles after it for a write.
- R6: The drive-enable is never high while output-enable is low. After output-enable rises, at least HZ_CYC cycles pass before the drive-enable rises.
- R7: host_req is looked at only in IDLE. The address, data and direction are taken at the accepting edge, and later changes on the host inputs do not affect that access.
- R8: The cycle counts follow from the parameters, with ceil(x) meaning ceil(x / CLK_PS), floored at 1:
  - RD_CYC = max(ceil(tAA), ceil(tRC), ceil(tOE))
  - WP_CYC = max(ceil(tWP), ceil(tDW), ceil(tAW), ceil(tWC) - 1)
  - HZ_CYC = ceil(tHZ)
  
  With a 4000 ps clock and the default figures these are 3, 2 and 2.
- R9: During a write, chip-select stays low for at least ceil(tWC / CLK_PS) cycles.
- R10: host_rdata changes only when a read is acknowledged. Writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Access request, sampled in IDLE |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 19 | Byte address |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Byte from the last read |
| host_ack | output | 1 | One-cycle completion pulse |
| sram_addr | output | 19 | Memory address bus |
| sram_ce_n | output | 1 | Chip-select, active low |
| sram_we_n | output | 1 | Write-strobe, active low |
| sram_oe_n | output | 1 | Output-enable, active low |
| sram_dq_out | output | 8 | Outgoing data byte |
| sram_dq_oe | output | 1 | Drive-enable for the outgoing byte |
| sram_dq_in | input | 8 | Incoming data byte from the memory |

## Verification
The hardest case to reach from the ports is a write that starts right after a read. In that case the memory may still be driving the bus while the controller prepares to drive it. The bench keeps host_req high from one table entry to the next, so each read is followed at once by a write waiting in IDLE.

The bench's memory model keeps driving for HZ_CYC cycles after output-enable rises and counts any overlap with the drive-enable. It also puts a garbage byte on the bus until the access time has elapsed, so a read that is sampled too early returns the wrong value.

// File: rtl/sramc_pkg.sv
`timescale 1ns/1ps
package sramc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_TURN,
        ST_WR_PULSE,
        ST_WR_HOLD
    } sramc_state_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } pin_ctl_t;

    function automatic int ps_to_cycles(input int span_ps, input int clk_ps);
        int n;
        n = (span_ps + clk_ps - 1) / clk_ps;
        if (n < 1) n = 1;
        return n;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic pin_ctl_t pins_for(input sramc_state_e s);
        pin_ctl_t p;
        unique case (s)
            ST_IDLE:      p = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
            ST_RD_ACCESS: p = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, dq_oe: 1'b0};
            ST_RD_TURN:   p = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
            ST_WR_PULSE:  p = '{ce_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, dq_oe: 1'b1};
            ST_WR_HOLD:   p = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b1};
            default:      p = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sramc_timer.sv
`timescale 1ns/1ps
module sramc_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sramc_fsm.sv
`timescale 1ns/1ps
module sramc_fsm
    import sramc_pkg::*;
#(
    parameter int CNT_W   = 2,
    parameter int RD_LAST = 2,
    parameter int WP_LAST = 1,
    parameter int HZ_LAST = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             wr,
    input  logic             expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             rd_capture,
    output logic             wr_finish,
    output logic             ce_n,
    output logic             we_n,
    output logic             oe_n,
    output logic             dq_oe
);

    sramc_state_e state_q;
    sramc_state_e state_n;
    pin_ctl_t     pins_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // transitions and phase timer loads
    always_comb begin
        state_n  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    tmr_load = 1'b1;
                    if (wr) begin
                        state_n = ST_WR_PULSE;
                        tmr_val = CNT_W'(WP_LAST);
                    end else begin
                        state_n = ST_RD_ACCESS;
                        tmr_val = CNT_W'(RD_LAST);
                    end
                end
            end
            ST_RD_ACCESS: begin
                if (expired) begin
                    state_n  = ST_RD_TURN;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(HZ_LAST);
                end
            end
            ST_RD_TURN: begin
                if (expired) state_n = ST_IDLE;
            end
            ST_WR_PULSE: begin
                if (expired) state_n = ST_WR_HOLD;
            end
            ST_WR_HOLD: begin
                state_n = ST_IDLE;
            end
            default: begin
                state_n = ST_IDLE;
            end
        endcase
    end

    assign accept     = (state_q == ST_IDLE) && req;
    assign rd_capture = (state_q == ST_RD_ACCESS) && expired;
    assign wr_finish  = (state_q == ST_WR_HOLD);

    // registered pin outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins_q <= pins_for(ST_IDLE);
        end else begin
            pins_q <= pins_for(state_n);
        end
    end

    assign ce_n  = pins_q.ce_n;
    assign we_n  = pins_q.we_n;
    assign oe_n  = pins_q.oe_n;
    assign dq_oe = pins_q.dq_oe;

endmodule

// File: rtl/sramc_datapath.sv
`timescale 1ns/1ps
module sramc_datapath #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              rd_capture,
    input  logic              wr_finish,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_ack
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              ack_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            ack_q   <= 1'b0;
        end else begin
            if (accept) begin
                addr_q  <= host_addr;
                wdata_q <= host_wdata;
            end
            if (rd_capture) begin
                rdata_q <= mem_dq_in;
            end
            ack_q <= rd_capture | wr_finish;
        end
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign host_rdata = rdata_q;
    assign host_ack   = ack_q;

endmodule

// File: rtl/sram_access_ctrl.sv
`timescale 1ns/1ps
module sram_access_ctrl
    import sramc_pkg::*;
#(
    parameter int ADDR_W  = 19,
    parameter int DATA_W  = 8,
    parameter int CLK_PS  = 4000,
    parameter int T_AA_PS = 10000,
    parameter int T_RC_PS = 10000,
    parameter int T_OE_PS = 4000,
    parameter int T_WC_PS = 10000,
    parameter int T_WP_PS = 7000,
    parameter int T_DW_PS = 5000,
    parameter int T_AW_PS = 7000,
    parameter int T_HZ_PS = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_ack,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);

    localparam int RD_CYC = imax(imax(ps_to_cycles(T_AA_PS, CLK_PS),
                                      ps_to_cycles(T_RC_PS, CLK_PS)),
                                 ps_to_cycles(T_OE_PS, CLK_PS));
    localparam int WP_CYC = imax(imax(ps_to_cycles(T_WP_PS, CLK_PS),
                                      ps_to_cycles(T_DW_PS, CLK_PS)),
                                 imax(ps_to_cycles(T_AW_PS, CLK_PS),
                                      ps_to_cycles(T_WC_PS, CLK_PS) - 1));
    localparam int HZ_CYC  = ps_to_cycles(T_HZ_PS, CLK_PS);
    localparam int MAX_CYC = imax(imax(RD_CYC, WP_CYC), HZ_CYC);
    localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             accept;
    logic             rd_capture;
    logic             wr_finish;

    sramc_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sramc_fsm #(
        .CNT_W   (CNT_W),
        .RD_LAST (RD_CYC - 1),
        .WP_LAST (WP_CYC - 1),
        .HZ_LAST (HZ_CYC - 1)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (host_req),
        .wr         (host_wr),
        .expired    (tmr_expired),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .accept     (accept),
        .rd_capture (rd_capture),
        .wr_finish  (wr_finish),
        .ce_n       (sram_ce_n),
        .we_n       (sram_we_n),
        .oe_n       (sram_oe_n),
        .dq_oe      (sram_dq_oe)
    );

    sramc_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .rd_capture (rd_capture),
        .wr_finish  (wr_finish),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .mem_dq_in  (sram_dq_in),
        .mem_addr   (sram_addr),
        .mem_dq_out (sram_dq_out),
        .host_rdata (host_rdata),
        .host_ack   (host_ack)
    );

endmodule

// File: rtl/sramc_chk.sv
`timescale 1ns/1ps
module sramc_chk
    import sramc_pkg::*;
#(
    parameter int ADDR_W  = 19,
    parameter int DATA_W  = 8,
    parameter int CLK_PS  = 4000,
    parameter int T_HZ_PS = 5000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sram_ce_n,
    input logic              sram_we_n,
    input logic              sram_oe_n,
    input logic              sram_dq_oe,
    input logic [ADDR_W-1:0] sram_addr,
    input logic [DATA_W-1:0] sram_dq_out,
    input logic              host_ack
);

    localparam int HZ_CYC = ps_to_cycles(T_HZ_PS, CLK_PS);

    logic [7:0] quiet_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet_q <= 8'hFF;
        end else if (!sram_oe_n) begin
            quiet_q <= 8'h00;
        end else if (quiet_q != 8'hFF) begin
            quiet_q <= quiet_q + 8'h01;
        end
    end

    // R1
    park_in_reset_chk: assert property (@(posedge clk)
        !rst_n |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe && !host_ack));

    // R2
    read_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (!sram_ce_n && sram_we_n));

    // R3
    write_oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (sram_oe_n && !sram_ce_n && sram_dq_oe));

    // R3
    write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n && !$past(sram_we_n)) |-> ($stable(sram_dq_out) && $stable(sram_addr)));

    // R4
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (!sram_ce_n && sram_dq_oe && $stable(sram_dq_out)));

    // R5
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);

    // R6
    no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> !sram_dq_oe);

    // R6
    bus_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_oe) |-> (int'(quiet_q) >= HZ_CYC));

endmodule

bind sram_access_ctrl sramc_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CLK_PS  (CLK_PS),
    .T_HZ_PS (T_HZ_PS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sram_ce_n   (sram_ce_n),
    .sram_we_n   (sram_we_n),
    .sram_oe_n   (sram_oe_n),
    .sram_dq_oe  (sram_dq_oe),
    .sram_addr   (sram_addr),
    .sram_dq_out (sram_dq_out),
    .host_ack    (host_ack)
);

// File: tb/sim_sram_access_ctrl.sv
`timescale 1ns/1ps
module sim_sram_access_ctrl;

    localparam int CLK_PS = 4000;
    localparam int T_AA = 10000, T_RC = 10000, T_OE = 4000, T_WC = 10000;
    localparam int T_WP = 7000, T_DW = 5000, T_AW = 7000, T_HZ = 5000;

    function automatic int cyc(input int ps);
        int n;
        n = (ps + CLK_PS - 1) / CLK_PS;
        return (n < 1) ? 1 : n;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_RD  = mx(mx(cyc(T_AA), cyc(T_RC)), cyc(T_OE));
    localparam int E_WP  = mx(mx(cyc(T_WP), cyc(T_DW)), mx(cyc(T_AW), cyc(T_WC) - 1));
    localparam int E_HZ  = cyc(T_HZ);
    localparam int E_ACC = mx(cyc(T_AA), cyc(T_OE));

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        host_req = 1'b0;
    logic        host_wr = 1'b0;
    logic [18:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_ack;
    logic [18:0] sram_addr;
    logic        sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [7:0]  sram_dq_out;
    logic [7:0]  sram_dq_in;

    always #2 clk = ~clk;

    sram_access_ctrl #(
        .CLK_PS (CLK_PS), .T_AA_PS (T_AA), .T_RC_PS (T_RC), .T_OE_PS (T_OE),
        .T_WC_PS (T_WC), .T_WP_PS (T_WP), .T_DW_PS (T_DW), .T_AW_PS (T_AW),
        .T_HZ_PS (T_HZ)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .host_req (host_req), .host_wr (host_wr),
        .host_addr (host_addr), .host_wdata (host_wdata), .host_rdata (host_rdata),
        .host_ack (host_ack), .sram_addr (sram_addr), .sram_ce_n (sram_ce_n),
        .sram_we_n (sram_we_n), .sram_oe_n (sram_oe_n), .sram_dq_out (sram_dq_out),
        .sram_dq_oe (sram_dq_oe), .sram_dq_in (sram_dq_in)
    );

    // ---------------- behavioural memory model ----------------
    logic [7:0] mem_store [int];
    logic [7:0] shadow [int];

    function automatic logic [7:0] fill(input logic [18:0] a);
        return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'h3C;
    endfunction

    function automatic logic [7:0] model_read(input logic [18:0] a);
        if (mem_store.exists(int'(a))) return mem_store[int'(a)];
        return fill(a);
    endfunction

    int          rd_run, we_run, dw_run, ce_run, tail;
    int          last_rd_run, last_we_run, last_ce_run;
    int          conflicts, wr_faults, hold_faults;
    logic [18:0] last_addr;
    logic [7:0]  last_dq;
    logic        prev_we_n, prev_ce_n;

    wire rd_act  = !sram_ce_n && sram_we_n && !sram_oe_n;
    wire [31:0] run_eff = (sram_addr == last_addr) ? rd_run : 0;
    wire data_ok = rd_act && (int'(run_eff) + 1 >= E_ACC);
    wire driving = rd_act || (tail != 0);

    assign sram_dq_in = data_ok ? model_read(sram_addr) : 8'hC3;

    always @(posedge clk) begin
        if (!rst_n) begin
            rd_run <= 0; we_run <= 0; dw_run <= 0; ce_run <= 0; tail <= 0;
            last_addr <= '0; last_dq <= '0; prev_we_n <= 1'b1; prev_ce_n <= 1'b1;
        end else begin
            if (sram_dq_oe && driving) conflicts = conflicts + 1;
            if (!sram_we_n && !sram_oe_n) wr_faults = wr_faults + 1;
            rd_run    <= rd_act ? int'(run_eff) + 1 : 0;
            if (rd_act) last_rd_run <= int'(run_eff) + 1;
            last_addr <= sram_addr;
            tail      <= rd_act ? E_HZ : ((tail != 0) ? tail - 1 : 0);
            dw_run    <= (!sram_we_n && sram_dq_oe) ?
                         ((sram_dq_out == last_dq && dw_run != 0) ? dw_run + 1 : 1) : 0;
            last_dq   <= sram_dq_out;
            if (!sram_we_n && !sram_ce_n) begin
                we_run <= we_run + 1;
            end else begin
                we_run <= 0;
            end
            if (!prev_we_n && sram_we_n && !sram_ce_n) begin
                if (we_run < cyc(T_WP) || dw_run < cyc(T_DW)) wr_faults = wr_faults + 1;
                if (!sram_dq_oe || sram_dq_out != last_dq) hold_faults = hold_faults + 1;
                mem_store[int'(sram_addr)] = sram_dq_out;
                last_we_run <= we_run;
            end
            ce_run <= !sram_ce_n ? ce_run + 1 : 0;
            if (!prev_ce_n && sram_ce_n) last_ce_run <= ce_run;
            prev_we_n <= sram_we_n;
            prev_ce_n <= sram_ce_n;
        end
    end

    // ---------------- checking ----------------
    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // drive at a negedge; returns at the negedge where ack is seen
    task automatic access(input bit w, input logic [18:0] a, input logic [7:0] d,
                          output int lat, output logic [7:0] rd);
        host_wr = w; host_addr = a; host_wdata = d; host_req = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!host_ack && lat < 64);
        check(host_ack == 1'b1, "R5", "ack seen", int'(host_ack), 1);
        rd = host_rdata;
        if (w) shadow[int'(a)] = d;
    endtask

    function automatic logic [7:0] expect_rd(input logic [18:0] a);
        if (shadow.exists(int'(a))) return shadow[int'(a)];
        return fill(a);
    endfunction

    // {wr, addr, data}
    localparam logic [27:0] VECS [10] = '{
        {1'b1, 19'h00000, 8'h11},
        {1'b1, 19'h7FFFF, 8'hEE},
        {1'b0, 19'h00000, 8'h00},
        {1'b0, 19'h7FFFF, 8'h00},
        {1'b1, 19'h12345, 8'hA5},
        {1'b1, 19'h12345, 8'h5A},
        {1'b0, 19'h12345, 8'h00},
        {1'b0, 19'h54321, 8'h00},
        {1'b1, 19'h40000, 8'h00},
        {1'b0, 19'h40000, 8'h00}
    };

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
        finish_run();
    end

    initial begin
        int lat;
        logic [7:0] rd;
        logic [7:0] keep;
        conflicts = 0; wr_faults = 0; hold_faults = 0;
        last_rd_run = 0; last_we_run = 0; last_ce_run = 0;
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: parked during reset
        check({sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, host_ack} == 5'b11100,
              "R1", "pins in reset", {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, host_ack}, 5'b11100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, host_ack} == 5'b11100,
              "R1", "pins idle", {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, host_ack}, 5'b11100);

        // table walk, request held high between entries (read then write back-to-back)
        for (int i = 0; i < 10; i++) begin
            access(VECS[i][27], VECS[i][26:8], VECS[i][7:0], lat, rd);
            if (!VECS[i][27])
                check(rd == expect_rd(VECS[i][26:8]), "R2", "table read data",
                      rd, expect_rd(VECS[i][26:8]));
        end
        host_req = 1'b0;
        repeat (6) @(negedge clk);

        // R5 R8: read latency from idle and exact strobe length
        access(1'b0, 19'h12345, 8'h00, lat, rd);
        host_req = 1'b0;
        check(lat == E_RD + 1, "R8", "read latency", lat, E_RD + 1);
        check(rd == 8'h5A, "R2", "read data", rd, 8'h5A);
        check(last_rd_run == E_RD, "R2", "oe low cycles", last_rd_run, E_RD);
        keep = host_rdata;
        @(negedge clk);
        check(host_ack == 1'b0, "R5", "ack width", int'(host_ack), 0);
        repeat (4) @(negedge clk);

        // R3 R9 R10: write from idle
        access(1'b1, 19'h00ABC, 8'h96, lat, rd);
        host_req = 1'b0;
        check(lat == E_WP + 2, "R5", "write latency", lat, E_WP + 2);
        check(host_rdata == keep, "R10", "rdata after write", host_rdata, keep);
        @(negedge clk);
        check(host_ack == 1'b0, "R5", "write ack width", int'(host_ack), 0);
        check(last_we_run == E_WP, "R3", "we low cycles", last_we_run, E_WP);
        check(last_ce_run >= cyc(T_WC), "R9", "ce low in write", last_ce_run, cyc(T_WC));
        repeat (3) @(negedge clk);

        // R7: host fields change right after acceptance
        host_wr = 1'b1; host_addr = 19'h0F0F0; host_wdata = 8'h3D; host_req = 1'b1;
        @(negedge clk);
        host_req = 1'b0; host_wr = 1'b0; host_addr = 19'h0F0F1; host_wdata = 8'h77;
        lat = 1;
        while (!host_ack && lat < 64) begin
            @(negedge clk);
            lat++;
        end
        shadow[int'(19'h0F0F0)] = 8'h3D;
        check(lat == E_WP + 2, "R7", "write kept direction", lat, E_WP + 2);
        repeat (3) @(negedge clk);
        access(1'b0, 19'h0F0F0, 8'h00, lat, rd);
        host_req = 1'b0;
        check(rd == 8'h3D, "R7", "captured address/data", rd, 8'h3D);
        repeat (3) @(negedge clk);
        access(1'b0, 19'h0F0F1, 8'h00, lat, rd);
        host_req = 1'b0;
        check(rd == fill(19'h0F0F1), "R7", "late fields ignored", rd, fill(19'h0F0F1));
        repeat (4) @(negedge clk);

        // R1 again, and bus/write-timing tallies from the model
        check({sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, host_ack} == 5'b11100,
              "R1", "pins parked after traffic", {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, host_ack}, 5'b11100);
        check(conflicts == 0, "R6", "bus conflicts", conflicts, 0);
        check(wr_faults == 0, "R3", "write setup/pulse faults", wr_faults, 0);
        check(hold_faults == 0, "R4", "write hold faults", hold_faults, 0);

        finish_run();
    end

endmodule